// File: doc/BRIEF.md
# Transition-serviced watchdog timer

This block supervises a host that must prove it is alive by toggling a service line. Time is measured in whole milliseconds from a single-cycle tick strobe supplied by a shared timebase. Every change of the service line, whichever direction, restarts the count. If the count reaches the selected timeout with no change seen, the block pulls its status output low and sends a one-clock request to a downstream reset generator. While the host stays silent, the count starts again and a fresh request follows each further timeout period.

The service line is asynchronous and passes through a two-stage synchronizer before edge detection. A select input picks the short or long timeout. Two hold conditions stop supervision entirely: a disable level, which stands for a service pin left floating or driven to mid-level, and a low-supply indication. While either is active, the count is cleared, no request is issued and the status output reads high. When both are released, a full timeout period is counted from zero.

Top module: `wdt_svc_top`

## Requirements
- R1: Either a rising or a falling change of `svc_i` restarts the count. A host that changes `svc_i` more often than once per timeout period never causes a request.
- R2: After the last restart, a request is issued once the selected number of ticks has arrived with no further change of `svc_i`. `expire_o` goes high in the clock that follows the final tick, and `ok_o` goes low in that same clock.
- R3: After a timeout, `ok_o` returns high on the next change of `svc_i`. This happens at the third rising clock edge after the change is applied.
- R4: While `dis_i` is 1, the count does not advance, `ok_o` is 1, `expire_o` stays 0, and changes of `svc_i` have no effect.
- R5: While `low_supply_i` is 1, `ok_o` is forced to 1 from the next clock and no request is issued, even if `ok_o` was low before.
- R6: With `slow_i` = 0 the timeout is FAST_MS ticks (default 100). With `slow_i` = 1 it is SLOW_MS ticks (default 1600).
- R7: If `svc_i` stays unchanged, requests repeat, one for each timeout period counted in ticks.
- R8: A hold (either `dis_i` or `low_supply_i`) clears the count. After release, the next request comes exactly one full timeout period of ticks after release.
- R9: Each `expire_o` pulse lasts exactly one clock.
- R10: After reset, `ok_o` = 1 and `expire_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle 1 ms timebase strobe |
| svc_i | input | 1 | Asynchronous service line from the host |
| dis_i | input | 1 | Disable level (service pin floating or at mid-level) |
| slow_i | input | 1 | Timeout select: 0 short, 1 long |
| low_supply_i | input | 1 | Low-supply indication; holds the watchdog off |
| ok_o | output | 1 | Status: 0 after a timeout until the next service change |
| expire_o | output | 1 | One-clock timeout request to the reset generator |

## Verification
A change on `svc_i` takes effect three rising edges later, after two synchronizer stages and the state register. The bench therefore applies each service change just after a tick, so the restart always lands before the next tick, and it checks `ok_o` four clocks after a change. A request follows the final tick by one clock. The scoreboard stores the expected tick index for each request, and the monitor compares it with the bench's own tick count at the falling edge where `expire_o` is high. Hold effects are sampled two clocks after the hold input changes, and queue-empty checks catch any request that was not expected.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    MODE_FAST = 1'b0,
    MODE_SLOW = 1'b1
  } wdt_mode_e;

  typedef struct packed {
    logic hold;
    logic edge_seen;
    logic tick;
  } wdt_ctl_t;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[STAGES-1];
  end

  // both directions restart the watchdog
  assign edge_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int unsigned FAST_MS = 100,
  parameter int unsigned SLOW_MS = 1600,
  localparam int unsigned MaxMs  = (SLOW_MS > FAST_MS) ? SLOW_MS : FAST_MS,
  localparam int unsigned CntW   = $clog2(MaxMs + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  wdt_ctl_t  ctl_i,
  input  wdt_mode_e mode_i,
  output logic      hit_o,
  output logic      expire_o
);
  localparam logic [CntW-1:0] FastLast = CntW'(FAST_MS - 1);
  localparam logic [CntW-1:0] SlowLast = CntW'(SLOW_MS - 1);

  logic [CntW-1:0] cnt_q;
  logic [CntW-1:0] last_val;
  logic            at_end;
  logic            expire_q;

  assign last_val = (mode_i == MODE_SLOW) ? SlowLast : FastLast;
  // >= covers a switch to the short mode with a count already past its end
  assign at_end   = (cnt_q >= last_val);
  assign hit_o    = !ctl_i.hold && !ctl_i.edge_seen && ctl_i.tick && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ctl_i.hold || ctl_i.edge_seen) begin
      cnt_q <= '0;
    end else if (ctl_i.tick) begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) expire_q <= 1'b0;
    else         expire_q <= hit_o;
  end

  assign expire_o = expire_q;
endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import wdt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wdt_ctl_t ctl_i,
  input  logic     hit_i,
  output logic     ok_o
);
  logic ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q <= 1'b1;
    end else if (ctl_i.hold || ctl_i.edge_seen) begin
      ok_q <= 1'b1;
    end else if (hit_i) begin
      ok_q <= 1'b0;
    end
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/wdt_svc_top.sv
module wdt_svc_top
  import wdt_pkg::*;
#(
  parameter int unsigned FAST_MS     = 100,
  parameter int unsigned SLOW_MS     = 1600,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic svc_i,
  input  logic dis_i,
  input  logic slow_i,
  input  logic low_supply_i,
  output logic ok_o,
  output logic expire_o
);
  logic      svc_edge;
  logic      hit;
  wdt_ctl_t  ctl;
  wdt_mode_e mode;

  assign ctl.hold      = dis_i | low_supply_i;
  assign ctl.edge_seen = svc_edge;
  assign ctl.tick      = tick_i;
  assign mode          = slow_i ? MODE_SLOW : MODE_FAST;

  wdt_sync #(
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (svc_i),
    .edge_o  (svc_edge)
  );

  wdt_count #(
    .FAST_MS (FAST_MS),
    .SLOW_MS (SLOW_MS)
  ) i_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_i    (ctl),
    .mode_i   (mode),
    .hit_o    (hit),
    .expire_o (expire_o)
  );

  wdt_status i_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl),
    .hit_i  (hit),
    .ok_o   (ok_o)
  );
endmodule

// File: rtl/wdt_svc_chk.sv
module wdt_svc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dis_i,
  input logic low_supply_i,
  input logic ok_o,
  input logic expire_o
);
  // R4
  disable_holds_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> (ok_o && !expire_o));

  // R5
  low_supply_holds_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_supply_i |=> (ok_o && !expire_o));

  // R2
  request_with_status_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> !ok_o);

  // R2
  status_falls_on_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ok_o) |-> expire_o);

  // R9
  single_cycle_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
endmodule

bind wdt_svc_top wdt_svc_chk i_wdt_svc_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dis_i        (dis_i),
  .low_supply_i (low_supply_i),
  .ok_o         (ok_o),
  .expire_o     (expire_o)
);

// File: tb/test_wdt_svc_top.sv
`timescale 1ns/1ps
module test_wdt_svc_top;
  localparam int FAST = 100;
  localparam int SLOW = 1600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic svc = 1'b0;
  logic dis = 1'b1;
  logic slow = 1'b0;
  logic low = 1'b0;
  logic ok, expire;

  int n_tests = 0;
  int n_fail  = 0;
  int tick_n  = 0;
  int div     = 0;
  int exp_q[$];
  bit done    = 1'b0;

  always #10 clk = ~clk;

  wdt_svc_top i_wdt_svc_top (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .svc_i(svc),
    .dis_i(dis), .slow_i(slow), .low_supply_i(low),
    .ok_o(ok), .expire_o(expire)
  );

  // tick generator: one strobe every 8 clocks
  always @(negedge clk) begin
    if (div == 7) begin
      div = 0;
      tick <= 1'b1;
      tick_n = tick_n + 1;
    end else begin
      div = div + 1;
      tick <= 1'b0;
    end
  end

  task automatic check(input bit c, input string req, input int act, input int expv);
    n_tests++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: compare each request with the queued tick index
  always @(negedge clk) begin
    if (rst_n && expire && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1/R4 unexpected request", tick_n, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(tick_n == e, "R2/R7 request tick", tick_n, e);
      end
    end
  end

  task automatic wait_tick();
    @(posedge clk);
    while (!tick) @(posedge clk);
    #1;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic push(input int t);
    exp_q.push_back(t);
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic toggle();
    svc = ~svc;
  endtask

  initial begin
    int n;
    clocks(3);
    // R10
    check(ok == 1'b1, "R10 ok after reset", ok, 1);
    check(expire == 1'b0, "R10 expire after reset", expire, 0);
    rst_n = 1'b1;

    // release disable, service often: R1 and R8
    wait_tick(); dis = 1'b0;
    for (int k = 0; k < 4; k++) begin
      wait_ticks(FAST / 2);
      toggle();
    end
    n = tick_n;
    check(ok == 1'b1, "R1 ok while serviced", ok, 1);
    check(exp_q.size() == 0, "R1 no request while serviced", exp_q.size(), 0);

    // no more service: R2, R7
    push(n + FAST); push(n + 2 * FAST);
    wait_ticks(2 * FAST); clocks(2);
    check(exp_q.size() == 0, "R7 two requests seen", exp_q.size(), 0);
    check(ok == 1'b0, "R2 ok low after timeout", ok, 0);

    // R3: next change restores ok
    wait_tick(); toggle(); n = tick_n;
    clocks(2);
    check(ok == 1'b0, "R3 ok still low before sync", ok, 0);
    clocks(2);
    check(ok == 1'b1, "R3 ok high after change", ok, 1);

    // R6: slow mode
    slow = 1'b1;
    wait_tick(); toggle(); n = tick_n;
    push(n + SLOW);
    wait_ticks(FAST + 5);
    check(ok == 1'b1, "R6 no short timeout in slow mode", ok, 1);
    wait_ticks(SLOW - FAST - 5); clocks(2);
    check(exp_q.size() == 0, "R6 slow request seen", exp_q.size(), 0);
    check(ok == 1'b0, "R6 ok low after slow timeout", ok, 0);

    // R5: low supply forces ok high
    slow = 1'b0;
    low = 1'b1; clocks(2);
    check(ok == 1'b1, "R5 ok forced high", ok, 1);
    wait_ticks(2 * FAST);
    check(ok == 1'b1, "R5 ok high during low supply", ok, 1);
    check(exp_q.size() == 0, "R5 no request during low supply", exp_q.size(), 0);
    wait_tick(); low = 1'b0; n = tick_n;
    push(n + FAST);
    wait_ticks(FAST); clocks(2);
    check(exp_q.size() == 0, "R8 full period after low supply", exp_q.size(), 0);

    // R4: disable ignores service changes
    wait_tick(); toggle();
    clocks(4); dis = 1'b1;
    wait_ticks(3 * FAST);
    toggle(); clocks(4);
    check(ok == 1'b1, "R4 ok high while disabled", ok, 1);
    check(exp_q.size() == 0, "R4 no request while disabled", exp_q.size(), 0);
    wait_tick(); dis = 1'b0; n = tick_n;
    push(n + FAST);
    wait_ticks(FAST / 2);
    check(ok == 1'b1, "R8 ok high mid period", ok, 1);
    wait_ticks(FAST - FAST / 2); clocks(2);
    check(exp_q.size() == 0, "R8 full period after disable", exp_q.size(), 0);
    check(ok == 1'b0, "R9 ok low after request", ok, 0);
    check(expire == 1'b0, "R9 request one clock", expire, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", tick_n, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule